// File: doc/BRIEF.md
# DMA Event Latch and Queue Dispatcher

This block collects transfer requests for a set of ordinary DMA channels and a smaller set of quick-DMA channels. It records each request as a pending bit and forwards pending channels, one per clock, to one of several transfer queues. A DMA channel can be requested in three ways. Software can issue a command on the command port. A peripheral can pulse an external event line. A completed transfer can pulse a chain line. A quick-DMA channel is requested when the parameter memory is written at the set and word that software has designated for it.

A per-channel enable mask filters the external event lines only. When a request arrives for a channel whose bit is still pending, a sticky missed flag is set and the error interrupt rises. The lowest-numbered pending channel whose queue is not full is dispatched, and its pending bit clears. Software also programs the channel-to-queue map, the quick-channel trigger words and a priority value for each queue over the command port.

Top module: `dma_event_dispatch`

## Requirements
- R1: After reset the following hold. No event is pending. No missed flag is set and err_irq is low. Every enable bit is 0. Every channel maps to queue 0. Queue q has priority q. Quick channel q is triggered by set q, word 2^WW-1.
- R2: Channel indices are numbered as follows. DMA channel i is pending bit i, and quick channel q is bit NCH+q. Each of the following sets the indexed bit on the next edge: a chain pulse on chain_evt[i]; command op 0 (SET) with cmd_chan<NCH+NQ. A SET op on a higher index does nothing.
- R3: ext_evt[i] sets bit i only while en_mask[i] is 1. Op 2 (EN) sets and op 3 (DIS) clears en_mask[cmd_chan]. Chain and SET triggers ignore the mask.
- R4: Quick channel q becomes pending when pw_valid is high and {pw_set, pw_word} equals its configured pair. Op 5 (QCFG) with cmd_chan=q loads the set from cmd_data[PSW-1:0] and the word from cmd_data[DW-1:PSW].
- R5: A pending bit stays set until it is dispatched or cleared by op 1 (CLR) on its index.
- R6: A trigger on a channel whose bit is set and is not dispatched in that cycle sets missed[ch] sticky. err_irq is the OR of all missed flags. Op 7 (CLRM) clears missed[cmd_chan].
- R7: disp_valid is high when some pending channel's queue is not full. disp_chan is then the lowest such index, disp_queue is that channel's mapped queue, and the bit clears on the next edge. At most one channel is dispatched per cycle.
- R8: A channel whose mapped queue has q_full set is not dispatched and stays pending. Op 4 (QMAP) sets the channel's queue to cmd_data[QW-1:0].
- R9: Op 6 (PRIO) with cmd_chan=q sets queue_prio[q*PW +: PW] to cmd_data[PW-1:0].
- R10: A trigger and a CLR on the same channel in the same cycle leave the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_evt | input | NCH | External event pulses |
| chain_evt | input | NCH | Chain trigger pulses |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode |
| cmd_chan | input | CW | Command channel, queue or quick index |
| cmd_data | input | DW | Command operand |
| pw_valid | input | 1 | Parameter memory write strobe |
| pw_set | input | PSW | Parameter set being written |
| pw_word | input | WW | Word within the set |
| q_full | input | NQUEUE | Per-queue full flags |
| evt_pend | output | NCH+NQ | Pending event bits |
| en_mask | output | NCH | External event enable bits |
| missed | output | NCH+NQ | Sticky missed-event flags |
| err_irq | output | 1 | Error interrupt |
| disp_valid | output | 1 | Dispatch this cycle |
| disp_chan | output | CW | Dispatched channel |
| disp_queue | output | QW | Queue of dispatched channel |
| queue_prio | output | NQUEUE*PW | Packed per-queue priorities |

## Verification
The bench uses the default parameters: 64 DMA channels, 8 quick channels and 4 queues. With these values the channel index is 7 bits wide. Command indices from 72 to 127 are therefore reachable and must be ignored, and the quick channels sit just above the last DMA channel, so arbitration crosses the boundary between the two groups. Four queues let one full queue hold its channels back while channels in the other queues keep flowing. This brings the R8 bypass within reach, both in directed cases and under random full flags.

// File: rtl/dma_event_dispatch.sv
module dma_event_dispatch #(
  parameter int NCH = 64,
  parameter int NQ = 8,
  parameter int NQUEUE = 4,
  parameter int PSW = 8,
  parameter int WW = 3,
  parameter int PW = 3,
  localparam int NT = NCH + NQ,
  localparam int CW = $clog2(NT),
  localparam int QW = $clog2(NQUEUE),
  localparam int DW = PSW + WW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       ext_evt,
  input  logic [NCH-1:0]       chain_evt,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_op,
  input  logic [CW-1:0]        cmd_chan,
  input  logic [DW-1:0]        cmd_data,
  input  logic                 pw_valid,
  input  logic [PSW-1:0]       pw_set,
  input  logic [WW-1:0]        pw_word,
  input  logic [NQUEUE-1:0]    q_full,
  output logic [NT-1:0]        evt_pend,
  output logic [NCH-1:0]       en_mask,
  output logic [NT-1:0]        missed,
  output logic                 err_irq,
  output logic                 disp_valid,
  output logic [CW-1:0]        disp_chan,
  output logic [QW-1:0]        disp_queue,
  output logic [NQUEUE*PW-1:0] queue_prio
);
  localparam logic [2:0] OP_SET = 3'd0, OP_CLR = 3'd1, OP_EN = 3'd2, OP_DIS = 3'd3,
                         OP_QMAP = 3'd4, OP_QCFG = 3'd5, OP_PRIO = 3'd6, OP_CLRM = 3'd7;

  logic [QW-1:0]  qmap  [NT];
  logic [PSW-1:0] qset  [NQ];
  logic [WW-1:0]  qword [NQ];
  logic [NT-1:0]  man, clr, mclr, trig, elig, disp_vec;
  logic [NQ-1:0]  qtrig;

  wire op_set  = cmd_valid && cmd_op == OP_SET;
  wire op_clr  = cmd_valid && cmd_op == OP_CLR;
  wire op_clrm = cmd_valid && cmd_op == OP_CLRM;

  always_comb begin
    for (int i = 0; i < NT; i++) begin
      man[i]  = op_set  && cmd_chan == CW'(i);
      clr[i]  = op_clr  && cmd_chan == CW'(i);
      mclr[i] = op_clrm && cmd_chan == CW'(i);
      elig[i] = evt_pend[i] && !q_full[qmap[i]];
    end
    for (int q = 0; q < NQ; q++)
      qtrig[q] = pw_valid && pw_set == qset[q] && pw_word == qword[q];
  end

  assign trig = {qtrig, (ext_evt & en_mask) | chain_evt} | man;

  always_comb begin
    disp_valid = 1'b0;
    disp_chan  = '0;
    disp_queue = '0;
    for (int i = NT - 1; i >= 0; i--)
      if (elig[i]) begin
        disp_valid = 1'b1;
        disp_chan  = CW'(i);
        disp_queue = qmap[i];
      end
  end

  always_comb
    for (int i = 0; i < NT; i++)
      disp_vec[i] = disp_valid && disp_chan == CW'(i);

  assign err_irq = |missed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_pend <= '0;
      missed   <= '0;
      en_mask  <= '0;
      for (int i = 0; i < NT; i++) qmap[i] <= '0;
      for (int q = 0; q < NQ; q++) begin
        qset[q]  <= PSW'(q);
        qword[q] <= '1;
      end
      for (int k = 0; k < NQUEUE; k++) queue_prio[k*PW +: PW] <= PW'(k);
    end else begin
      evt_pend <= (evt_pend & ~disp_vec & ~clr) | trig;
      missed   <= (missed & ~mclr) | (trig & evt_pend & ~disp_vec);
      if (cmd_valid) begin
        for (int i = 0; i < NCH; i++)
          if (cmd_chan == CW'(i)) begin
            if (cmd_op == OP_EN)  en_mask[i] <= 1'b1;
            if (cmd_op == OP_DIS) en_mask[i] <= 1'b0;
          end
        for (int i = 0; i < NT; i++)
          if (cmd_op == OP_QMAP && cmd_chan == CW'(i)) qmap[i] <= cmd_data[QW-1:0];
        for (int q = 0; q < NQ; q++)
          if (cmd_op == OP_QCFG && cmd_chan == CW'(q)) begin
            qset[q]  <= cmd_data[PSW-1:0];
            qword[q] <= cmd_data[DW-1:PSW];
          end
        for (int k = 0; k < NQUEUE; k++)
          if (cmd_op == OP_PRIO && cmd_chan == CW'(k)) queue_prio[k*PW +: PW] <= cmd_data[PW-1:0];
      end
    end
  end

  p_disp_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> evt_pend[disp_chan]);
  p_disp_not_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> !q_full[disp_queue]);
  p_disp_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && !trig[disp_chan] |=> !evt_pend[$past(disp_chan)]);
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq && !op_clrm |=> err_irq);
  p_pend_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid && !disp_valid |=> (evt_pend & $past(evt_pend)) == $past(evt_pend));
  p_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid && !pw_valid && chain_evt == '0 && (ext_evt & en_mask) == '0
    |=> (evt_pend & ~$past(evt_pend)) == '0);
endmodule

// File: tb/dma_event_dispatch_test.sv
module dma_event_dispatch_test;
  localparam int NCH = 64, NQ = 8, NQUEUE = 4, PSW = 8, WW = 3, PW = 3;
  localparam int NT = NCH + NQ, CW = $clog2(NT), QW = $clog2(NQUEUE), DW = PSW + WW;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] ext_evt = '0, chain_evt = '0;
  logic cmd_valid = 0;
  logic [2:0] cmd_op = '0;
  logic [CW-1:0] cmd_chan = '0;
  logic [DW-1:0] cmd_data = '0;
  logic pw_valid = 0;
  logic [PSW-1:0] pw_set = '0;
  logic [WW-1:0] pw_word = '0;
  logic [NQUEUE-1:0] q_full = '1;
  logic [NT-1:0] evt_pend, missed;
  logic [NCH-1:0] en_mask;
  logic err_irq, disp_valid;
  logic [CW-1:0] disp_chan;
  logic [QW-1:0] disp_queue;
  logic [NQUEUE*PW-1:0] queue_prio;

  dma_event_dispatch uut (.*);

  always #4 clk = ~clk;

  int checks = 0, failures = 0;
  string tag = "R1";
  bit done = 0;

  logic [NT-1:0] m_pend, m_miss;
  logic [NCH-1:0] m_en;
  int m_qmap[NT], m_qset[NQ], m_qword[NQ], m_prio[NQUEUE];
  bit e_dv; int e_dc, e_dq;

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pend = '0; m_miss = '0; m_en = '0;
    foreach (m_qmap[i]) m_qmap[i] = 0;
    foreach (m_qset[q]) begin m_qset[q] = q; m_qword[q] = (1 << WW) - 1; end
    foreach (m_prio[k]) m_prio[k] = k;
  endtask

  task automatic model_eval();
    e_dv = 0; e_dc = 0; e_dq = 0;
    for (int i = 0; i < NT; i++)
      if (!e_dv && m_pend[i] && !q_full[m_qmap[i]]) begin
        e_dv = 1; e_dc = i; e_dq = m_qmap[i];
      end
  endtask

  task automatic compare();
    logic [NQUEUE*PW-1:0] ep;
    model_eval();
    for (int k = 0; k < NQUEUE; k++) ep[k*PW +: PW] = PW'(m_prio[k]);
    chk("evt_pend_lo", evt_pend[63:0], m_pend[63:0]);
    chk("evt_pend_hi", evt_pend[NT-1:64], m_pend[NT-1:64]);
    chk("en_mask", en_mask, m_en);
    chk("missed_lo", missed[63:0], m_miss[63:0]);
    chk("missed_hi", missed[NT-1:64], m_miss[NT-1:64]);
    chk("err_irq", err_irq, |m_miss);
    chk("disp_valid", disp_valid, e_dv);
    if (e_dv) begin
      chk("disp_chan", disp_chan, e_dc);
      chk("disp_queue", disp_queue, e_dq);
    end
    chk("queue_prio", queue_prio, ep);
  endtask

  task automatic model_step();
    logic [NT-1:0] t;
    int c;
    c = int'(cmd_chan);
    for (int i = 0; i < NCH; i++)
      t[i] = (ext_evt[i] && m_en[i]) || chain_evt[i];
    for (int q = 0; q < NQ; q++)
      t[NCH+q] = pw_valid && int'(pw_set) == m_qset[q] && int'(pw_word) == m_qword[q];
    if (cmd_valid && cmd_op == 0 && c < NT) t[c] = 1;
    for (int i = 0; i < NT; i++) begin
      bit d, cl;
      d = e_dv && e_dc == i;
      cl = cmd_valid && cmd_op == 1 && c == i;
      if (t[i] && m_pend[i] && !d) m_miss[i] = 1;
      else if (cmd_valid && cmd_op == 7 && c == i) m_miss[i] = 0;
      m_pend[i] = t[i] || (m_pend[i] && !d && !cl);
    end
    if (cmd_valid) begin
      if (cmd_op == 2 && c < NCH) m_en[c] = 1;
      if (cmd_op == 3 && c < NCH) m_en[c] = 0;
      if (cmd_op == 4 && c < NT) m_qmap[c] = int'(cmd_data[QW-1:0]);
      if (cmd_op == 5 && c < NQ) begin
        m_qset[c] = int'(cmd_data[PSW-1:0]);
        m_qword[c] = int'(cmd_data[DW-1:PSW]);
      end
      if (cmd_op == 6 && c < NQUEUE) m_prio[c] = int'(cmd_data[PW-1:0]);
    end
  endtask

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      #1;
      compare();
      model_step();
      @(negedge clk);
      ext_evt = '0; chain_evt = '0; cmd_valid = 0; pw_valid = 0;
    end
  endtask

  task automatic cmd(int op, int ch, int data);
    cmd_valid = 1; cmd_op = 3'(op); cmd_chan = CW'(ch); cmd_data = DW'(data);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1"; tick(2);
    tag = "R2";
    cmd(0, 5, 0); tick();
    chain_evt[10] = 1; tick();
    cmd(0, 100, 0); tick();
    cmd(0, 70, 0); tick();
    tag = "R3";
    ext_evt[20] = 1; tick();
    cmd(2, 3, 0); tick();
    ext_evt[3] = 1; ext_evt[20] = 1; tick();
    cmd(3, 3, 0); tick();
    ext_evt[3] = 1; tick();
    cmd(2, 66, 0); tick();
    tag = "R4";
    pw_valid = 1; pw_set = 1; pw_word = 7; tick();
    pw_valid = 1; pw_set = 2; pw_word = 6; tick();
    cmd(5, 2, (3 << PSW) | 40); tick();
    pw_valid = 1; pw_set = 2; pw_word = 7; tick();
    pw_valid = 1; pw_set = 40; pw_word = 3; tick();
    tag = "R5";
    tick(3);
    cmd(1, 10, 0); tick();
    tag = "R10";
    cmd(1, 5, 0); chain_evt[5] = 1; tick();
    tag = "R6";
    cmd(0, 3, 0); tick();
    cmd(7, 5, 0); tick();
    cmd(7, 3, 0); tick();
    tag = "R9";
    cmd(6, 2, 5); tick();
    cmd(6, 3, 0); tick();
    tag = "R8";
    cmd(4, 3, 2); tick();
    cmd(4, 65, 1); tick();
    q_full = 4'b0100; tick(8);
    tag = "R7";
    q_full = 4'b0000; cmd(0, 0, 0); chain_evt[1] = 1; tick(4);
    chain_evt[0] = 1; chain_evt[63] = 1; tick(4);
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 3 == 0) ext_evt = NCH'(1) << ($urandom % NCH);
      if ($urandom % 3 == 0) chain_evt = NCH'(1) << ($urandom % NCH);
      if ($urandom % 2 == 0) cmd(int'($urandom % 8), int'($urandom % 128), int'($urandom));
      if ($urandom % 3 == 0) begin
        pw_valid = 1; pw_set = PSW'($urandom % 12); pw_word = WW'($urandom);
      end
      q_full = NQUEUE'($urandom);
      tag = (n % 2 == 0) ? "R7" : "R8";
      tick();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule